// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Sample Voting

This block receives asynchronous serial frames on a single line. An enable input marks the cycles of an oversampling clock that runs at sixteen times the bit rate. The line passes through a two-flop synchronizer and is then sampled only on enabled cycles. A falling edge on an idle-high line starts a frame. Every bit of the frame is decided by majority vote over its samples 8, 9 and 10: the start bit, each payload bit and the stop bit.

The payload is 8 or 9 bits, chosen by a length input, and arrives least-significant bit first. When the stop bit has been voted, the block emits the word with a one-cycle valid strobe. A noise flag and a framing flag are valid in that same cycle. If the start bit votes high, the block treats it as a glitch and goes back to idle without reporting anything.

Top module: `uart_vote_rx`

## Requirements
- R1: The serial input passes through two flip-flops before it is sampled. A change on `rxd` before clock edge k is first seen by the sampling logic at edge k+2.
- R2: The sample counter moves only on clock edges where `os_tick` is 1. Edges without `os_tick` change no receiver state.
- R3: The low sample that follows a high sample counts as sample 1 of the start bit. Each bit spans 16 ticks, and its value is the majority of its samples 8, 9 and 10. A sample outside that window has no effect on the word or the flags.
- R4: Payload bits arrive LSB first. With `len9`=0 the word has 8 bits and `rx_data[8]` is 0. With `len9`=1 the word has 9 bits. `len9` is captured when the start edge is detected.
- R5: A start bit whose samples 8, 9 and 10 vote high ends the frame attempt, and no `rx_valid` is produced for it.
- R6: `noise_err` is 1 when any start or payload bit has samples that disagree, or when the stop bit's three samples are not all 1.
- R7: `frame_err` is 1 when the stop bit's samples vote 0. Any framing error also sets `noise_err`.
- R8: `rx_valid` pulses for exactly one clock, at the edge of the stop bit's sample-10 tick. The flags are nonzero only in that cycle. After it the receiver waits for the next falling edge.
- R9: Sample 8 of the stop bit is taken 16·(n+1)+7 ticks after start sample 1, where n is the payload length. `rx_valid` therefore rises 16·(n+1)+9 ticks after start sample 1.
- R10: During and right after reset, `rx_valid`, `noise_err`, `frame_err` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| len9 | input | 1 | 1: 9 payload bits, 0: 8 payload bits |
| rx_data | output | 9 | Last received word, LSB-aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| noise_err | output | 1 | Sample disagreement in the frame (valid with strobe) |
| frame_err | output | 1 | Stop bit voted low (valid with strobe) |

## Verification
Every result appears at the edge of the tick that carries the stop bit's sample 10. Counting the two synchronizer stages, that tick reflects `rxd` as it was two clock edges earlier. That is 16·(n+1)+9 ticks after start sample 1, plus any clocks without a tick in between. The bench model replays the same two-stage delay and runs its own bit timing on the ticks it drove. It then compares the strobe on every clock, and the word and flags in each strobe cycle, 1 ns after the edge. Glitches inside and outside the voting window, a stalled tick, a false start and a low stop bit each shift or suppress the strobe in a way the model predicts tick by tick.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BITS = 1'b1} rx_state_t;

  // majority of three samples
  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // samples disagree
  function automatic logic split3(input logic [2:0] s);
    return (|s) & ~(&s);
  endfunction

  function automatic logic allone3(input logic [2:0] s);
    return &s;
  endfunction
endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uvr_timer.sv
module uvr_timer #(
  parameter int OS_RATE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic run,
  output logic smp_ev,
  output logic vote_ev
);
  localparam int CW  = $clog2(OS_RATE + 1);
  localparam int MID = OS_RATE / 2;

  logic [CW-1:0] cnt, nxt;

  assign nxt     = (cnt == CW'(OS_RATE)) ? CW'(1) : cnt + CW'(1);
  assign smp_ev  = tick && run && (nxt >= CW'(MID)) && (nxt <= CW'(MID + 2));
  assign vote_ev = tick && run && (nxt == CW'(MID + 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (tick) begin
      if (start)     cnt <= CW'(1);
      else if (run)  cnt <= nxt;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt >= CW'(1) && cnt <= CW'(OS_RATE)));
endmodule

// File: rtl/uvr_voter.sv
module uvr_voter (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_ev,
  input  logic vote_ev,
  input  logic line,
  output logic maj,
  output logic split,
  output logic allone
);
  import uvr_pkg::*;

  logic [1:0] win;
  logic [2:0] trio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  win <= '0;
    else if (smp_ev && !vote_ev) win <= {win[0], line};
  end

  assign trio   = {win[1], win[0], line};
  assign maj    = maj3(trio);
  assign split  = split3(trio);
  assign allone = allone3(trio);

  // R3
  vote_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_ev |-> smp_ev);
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 9,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              len9,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              noise_err,
  output logic              frame_err
);
  import uvr_pkg::*;

  localparam int BW = $clog2(DATA_W + 2);
  localparam int IW = $clog2(DATA_W);

  rx_state_t         state;
  logic              line, line_q, len_q;
  logic [BW-1:0]     bidx, nbits;
  logic [DATA_W-1:0] word;
  logic              noise_acc;
  logic              fall_ev, start_ev, smp_ev, vote_ev;
  logic              v_maj, v_split, v_allone;

  uvr_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line));

  assign fall_ev  = line_q && !line;
  assign start_ev = os_tick && (state == ST_IDLE) && fall_ev;
  assign nbits    = len_q ? BW'(DATA_W) : BW'(DATA_W - 1);

  uvr_timer #(.OS_RATE(OS_RATE)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .start(start_ev),
    .run(state == ST_BITS), .smp_ev(smp_ev), .vote_ev(vote_ev));

  uvr_voter u_voter (
    .clk(clk), .rst_n(rst_n), .smp_ev(smp_ev), .vote_ev(vote_ev),
    .line(line), .maj(v_maj), .split(v_split), .allone(v_allone));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      line_q    <= 1'b1;
      len_q     <= 1'b0;
      bidx      <= '0;
      word      <= '0;
      noise_acc <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      noise_err <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      noise_err <= 1'b0;
      frame_err <= 1'b0;
      if (os_tick) line_q <= line;
      if (start_ev) begin
        state     <= ST_BITS;
        bidx      <= '0;
        word      <= '0;
        noise_acc <= 1'b0;
        len_q     <= len9;
      end else if (vote_ev) begin
        if (bidx == '0) begin
          if (v_maj) state <= ST_IDLE;
          noise_acc <= v_split;
          bidx      <= BW'(1);
        end else if (bidx <= nbits) begin
          word[IW'(bidx - BW'(1))] <= v_maj;
          noise_acc <= noise_acc | v_split;
          bidx      <= bidx + BW'(1);
        end else begin
          rx_valid  <= 1'b1;
          rx_data   <= word;
          noise_err <= noise_acc | !v_allone;
          frame_err <= !v_maj;
          state     <= ST_IDLE;
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8
  flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err || frame_err) |-> rx_valid);
  // R7
  frame_noise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> noise_err);
  // R4
  short_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !len_q) |-> !rx_data[DATA_W-1]);
  // R8
  valid_after_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(vote_ev) && $past(state) == ST_BITS));
  // R5
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_BITS));
endmodule

// File: tb/uart_vote_rx_tb.sv
module uart_vote_rx_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       os_tick = 0;
  logic       rxd = 1;
  logic       len9 = 0;
  logic [8:0] rx_data;
  logic       rx_valid, noise_err, frame_err;

  int errors = 0, checks = 0, dut_frames = 0;
  bit done = 0;

  uart_vote_rx u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .len9(len9),
    .rx_data(rx_data), .rx_valid(rx_valid), .noise_err(noise_err),
    .frame_err(frame_err));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int s1m = 1, s2m = 1, m_prev = 1, m_act = 0, m_cnt = 0, m_bit = 0, m_len = 8;
  int m_data = 0, m_noise = 0, q[$];
  int rx_e, tk_e, ln_e, rs_e;

  always @(posedge clk) begin
    int line, ones, e_val, e_noise, e_frame;
    rx_e = rxd; tk_e = os_tick; ln_e = len9; rs_e = rst_n;
    #1;
    e_val = 0; e_noise = 0; e_frame = 0;
    if (!rs_e) begin
      s1m = 1; s2m = 1; m_prev = 1; m_act = 0; q.delete();
    end else begin
      line = s2m; s2m = s1m; s1m = rx_e;      // R1 two-edge delay
      if (tk_e) begin                          // R2 ticks only
        if (!m_act) begin
          if (m_prev == 1 && line == 0) begin  // R5 edge
            m_act = 1; m_cnt = 1; m_bit = 0; m_len = ln_e ? 9 : 8;
            m_data = 0; m_noise = 0; q.delete();
          end
        end else begin
          m_cnt = (m_cnt == 16) ? 1 : m_cnt + 1;
          if (m_cnt >= 8 && m_cnt <= 10) q.push_back(line);   // R3
          if (m_cnt == 10) begin
            ones = 0;
            foreach (q[i]) ones += q[i];
            q.delete();
            if (m_bit == 0) begin
              if (ones >= 2) m_act = 0;
              m_noise = (ones == 1 || ones == 2);
            end else if (m_bit <= m_len) begin
              if (ones >= 2) m_data |= (1 << (m_bit - 1));     // R4
              if (ones == 1 || ones == 2) m_noise = 1;
            end else begin                      // R9 stop vote timing
              e_val = 1;
              e_noise = m_noise | (ones != 3); // R6
              e_frame = (ones < 2);            // R7
              m_act = 0;
            end
            m_bit++;
          end
        end
        m_prev = line;
      end
      if (rx_valid) dut_frames++;
      chk(rx_valid == e_val, "R8 valid timing", rx_valid, e_val);
      if (e_val && rx_valid) begin
        chk(rx_data == m_data[8:0], "R4 word", rx_data, m_data);
        chk(noise_err == e_noise, "R6 noise", noise_err, e_noise);
        chk(frame_err == e_frame, "R7 framing", frame_err, e_frame);
      end else if (!rx_valid) begin
        chk(!noise_err && !frame_err, "R8 flags idle", {noise_err, frame_err}, 0);
      end
    end
  end

  task automatic step(input int v);
    @(negedge clk); rxd = v[0]; os_tick = 1;
    @(negedge clk); os_tick = 0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1);
  endtask

  task automatic send(input int val, input int n, input int stop_v,
                      input int gb, input int gs, input int stall_b);
    @(negedge clk); len9 = (n == 9);
    for (int b = 0; b < n + 2; b++) begin
      for (int s = 1; s <= 16; s++) begin
        int v;
        v = (b == 0) ? 0 : (b == n + 1) ? stop_v : ((val >> (b - 1)) & 1);
        if (b == gb && s == gs) v = 1 - v;
        step(v);
        if (b == stall_b && s == 5) repeat (7) @(negedge clk);
      end
    end
    idle(20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(rx_valid == 0, "R10 valid", rx_valid, 0);
    chk(rx_data == 0, "R10 data", rx_data, 0);
    chk(!noise_err && !frame_err, "R10 flags", {noise_err, frame_err}, 0);
    rst_n = 1;
    idle(10);
    send(8'h55, 8, 1, -1, 0, -1);
    send(8'hA3, 8, 1, -1, 0, -1);
    send(9'h1C5, 9, 1, -1, 0, -1);     // R4 ninth bit
    send(8'h3C, 8, 1, 3, 9, -1);       // R6 payload glitch inside window
    send(8'h81, 8, 1, 4, 3, -1);       // R3 glitch outside window
    send(8'h0F, 8, 0, -1, 0, -1);      // R7 low stop
    send(8'h66, 8, 1, 9, 10, -1);      // R6 stop glitch
    for (int i = 0; i < 5; i++) step(0); // R5 false start
    idle(40);
    send(8'h99, 8, 1, 0, 9, -1);       // R6 start glitch
    send(9'h12A, 9, 1, -1, 0, 4);      // R2 stalled tick
    idle(10);
    chk(dut_frames == 9, "R5 frame count", dut_frames, 9);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule